// File: doc/BRIEF.md
# Three-wire serial timekeeper master

This block drives a serial real-time-clock device over three wires: a chip-enable strobe, a serial clock and a shared bidirectional data line. A host hands it a single command through a valid/ready port (register read or write, scratch RAM read or write, a charger setting write, a presence probe, or a clock-start step), and the block produces the complete pin sequence for that command: the framed transactions, the command byte, the bit timing and the output enable for the data line.

Every write to a clock register or RAM cell is bracketed by two extra framed transactions on the control register. The first clears write protection and the second sets it again, so the device is left protected between host commands. A read-only input blocks every write except a write that targets the charger register. The probe writes a known pattern into RAM cell 0 and reads it back. The clock-start step reads the seconds register and writes it back with its halt bit cleared.

All pin timing is built from a clock-enable divider. One tick is one SCL half-period, and the strobe setup and hold times are whole numbers of ticks.

Top module: `rtc3w_master`

## Requirements
- R1: When the block is idle, `rtc_ce` and `rtc_sclk` are low. Each transaction starts with `rtc_sclk` low and `rtc_ce` low for at least `CE_SETUP_TICKS` ticks. `rtc_ce` then rises and stays high through 16 SCL pulses and `CE_HOLD_TICKS` further ticks, and then falls.
- R2: Command and write bytes leave least significant bit first on `rtc_dq_o`. The data line changes only while `rtc_sclk` is low, so it is stable at each rising edge and during each high phase.
- R3: `rtc_dq_oe` is high only during the command byte and the write data byte of a transaction. It is low for the 8 read bits and outside transactions.
- R4: During a read, the block samples `rtc_dq_i` once in each of the 8 low phases that follow the command byte. It assembles the bits LSB first and returns the byte on `rsp_data` with `done`.
- R5: The command byte is `{1, space, index[4:0], dir}`. Here space is 0 for a clock register and 1 for RAM, and dir is 1 for a read and 0 for a write. Examples: register 2 write is 0x84, RAM 5 read is 0xCB.
- R6: Each register or RAM write runs three transactions in order. The first is command 0x8E with data 0x00, the second is the write itself, and the third is command 0x8E with data 0x80.
- R7: While `read_only` is 1 at acceptance, a register or RAM write produces no transaction and finishes with `rsp_ok`=0. The exception is a write to register index 8 (the charger register).
- R8: Op 6 (charger) writes `0xA0 | cmd_wdata[3:0]` to register index 8 (command 0x90). It is wrapped as in R6, and it runs even in read-only mode.
- R9: Op 4 (probe) runs four transactions: unlock, write 0x42 with command 0xC0, read with command 0xC1, then lock. `rsp_data` is the byte read back, and `rsp_ok` is 1 only if that byte equals 0x42.
- R10: Op 5 (clock start) reads register 0 (command 0x81) and returns the byte read on `rsp_data`. Unless `read_only` is set, it then writes that byte with bit 7 cleared to register 0 (command 0x80), wrapped as in R6.
- R11: `cmd_ready` equals `!busy`. A command is taken only when `cmd_valid` and `cmd_ready` are both high, and commands offered while busy are ignored. Each accepted command gives exactly one single-cycle `done` pulse.
- R12: Every SCL high phase lasts exactly `CLK_DIV` clock cycles.
- R13: Op codes are 0 register read, 1 register write, 2 RAM read, 3 RAM write, 4 probe, 5 clock start, 6 charger. Code 7 finishes with no transaction and `rsp_ok`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_op | input | 3 | Operation code (R13) |
| cmd_addr | input | 5 | Register or RAM index |
| cmd_wdata | input | 8 | Write data (low 4 bits for charger op) |
| read_only | input | 1 | Blocks writes other than charger |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| rsp_data | output | 8 | Byte read by the operation |
| rsp_ok | output | 1 | Write performed / probe matched |
| rtc_ce | output | 1 | Device chip enable |
| rtc_sclk | output | 1 | Serial clock |
| rtc_dq_o | output | 1 | Serial data out |
| rtc_dq_oe | output | 1 | Serial data output enable |
| rtc_dq_i | input | 1 | Serial data in |

## Verification
The assertions assume that the host holds `cmd_op`, `cmd_addr`, `cmd_wdata` and `read_only` steady while `cmd_valid` is high. They also assume that `rtc_dq_i` is only meaningful while `rtc_dq_oe` is low. The bench keeps to both. It drives the command fields and `read_only` only on falling clock edges around a single-cycle valid pulse, and its device model changes `rtc_dq_i` only after the command byte of a read has been clocked in. The model also counts any output enable it sees during read bits, so a violation of R3 shows up even where no assertion covers it.

// File: rtl/rtc3w_pkg.sv
package rtc3w_pkg;
  typedef enum logic [2:0] {
    OP_REG_RD  = 3'd0,
    OP_REG_WR  = 3'd1,
    OP_RAM_RD  = 3'd2,
    OP_RAM_WR  = 3'd3,
    OP_PROBE   = 3'd4,
    OP_INIT    = 3'd5,
    OP_TRICKLE = 3'd6,
    OP_NONE    = 3'd7
  } op_e;

  localparam logic [4:0] SEC_IDX     = 5'd0;
  localparam logic [4:0] TRICKLE_IDX = 5'd8;
  localparam logic [7:0] CTRL_CMD    = 8'h8E;
  localparam logic [7:0] WP_CLEAR    = 8'h00;
  localparam logic [7:0] WP_SET      = 8'h80;
  localparam logic [7:0] PROBE_PAT   = 8'h42;
  localparam logic [3:0] TRICKLE_HI  = 4'hA;
endpackage

// File: rtl/rtc3w_tick.sv
module rtc3w_tick #(
  parameter int DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_comb begin
    if (clr || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rtc3w_frame.sv
module rtc3w_frame #(
  parameter int SETUP_TICKS = 5,
  parameter int HOLD_TICKS  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic [7:0] cmd,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       fdone,
  output logic [7:0] rdata,
  output logic       ce,
  output logic       sclk,
  output logic       dq_o,
  output logic       dq_oe,
  input  logic       dq_i
);
  localparam int MAXD = (SETUP_TICKS > HOLD_TICKS) ? SETUP_TICKS : HOLD_TICKS;
  localparam int DW   = $clog2(MAXD + 1);
  localparam logic [3:0] LAST_BIT = 4'd15;

  typedef enum logic [2:0] {F_IDLE, F_SETUP, F_LO, F_HI, F_HOLD} fst_e;

  fst_e        st_q, st_d;
  logic [DW-1:0] dcnt_q, dcnt_d;
  logic [3:0]  bit_q, bit_d;
  logic [15:0] sh_q, sh_d;
  logic [7:0]  rx_q, rx_d;
  logic        wr_q, wr_d;

  always_comb begin
    st_d   = st_q;
    dcnt_d = dcnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    wr_d   = wr_q;
    fdone  = 1'b0;
    case (st_q)
      F_IDLE: if (start) begin
        st_d   = F_SETUP;
        dcnt_d = '0;
        bit_d  = '0;
        sh_d   = {wdata, cmd};
        wr_d   = wr;
      end
      F_SETUP: if (tick) begin
        if (dcnt_q == DW'(SETUP_TICKS - 1)) st_d = F_LO;
        else dcnt_d = dcnt_q + 1'b1;
      end
      F_LO: if (tick) begin
        if (bit_q[3]) rx_d = {dq_i, rx_q[7:1]};
        st_d = F_HI;
      end
      F_HI: if (tick) begin
        if (bit_q == LAST_BIT) begin
          st_d   = F_HOLD;
          dcnt_d = '0;
        end else begin
          bit_d = bit_q + 1'b1;
          sh_d  = {1'b0, sh_q[15:1]};
          st_d  = F_LO;
        end
      end
      F_HOLD: if (tick) begin
        if (dcnt_q == DW'(HOLD_TICKS - 1)) begin
          st_d  = F_IDLE;
          fdone = 1'b1;
        end else dcnt_d = dcnt_q + 1'b1;
      end
      default: st_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= F_IDLE;
      dcnt_q <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      wr_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      dcnt_q <= dcnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      wr_q   <= wr_d;
    end
  end

  assign ce    = (st_q == F_LO) || (st_q == F_HI) || (st_q == F_HOLD);
  assign sclk  = (st_q == F_HI);
  assign dq_o  = sh_q[0];
  assign dq_oe = ((st_q == F_LO) || (st_q == F_HI)) && (wr_q || !bit_q[3]);
  assign rdata = rx_q;
endmodule

// File: rtl/rtc3w_seq.sv
module rtc3w_seq
  import rtc3w_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic [4:0] cmd_addr,
  input  logic [7:0] cmd_wdata,
  input  logic       read_only,
  output logic       busy,
  output logic       done,
  output logic [7:0] rsp_data,
  output logic       rsp_ok,
  output logic       frm_start,
  output logic [7:0] frm_cmd,
  output logic       frm_wr,
  output logic [7:0] frm_wdata,
  input  logic       frm_done,
  input  logic [7:0] frm_rdata
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_UNLK, ST_WR, ST_LOCK, ST_PWR, ST_PRD, ST_DONE
  } st_e;

  st_e        st_q, st_d;
  op_e        op_q, op_d;
  logic [4:0] addr_q, addr_d;
  logic       ram_q, ram_d;
  logic [7:0] wd_q, wd_d;
  logic [7:0] rsp_q, rsp_d;
  logic       ok_q, ok_d;
  logic       ro_q, ro_d;
  logic       wait_q, wait_d;
  logic       frame_step;

  assign frame_step = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign frm_start  = frame_step && !wait_q;

  always_comb begin
    frm_cmd   = CTRL_CMD;
    frm_wr    = 1'b1;
    frm_wdata = WP_CLEAR;
    case (st_q)
      ST_RD:   begin frm_cmd = {1'b1, ram_q, addr_q, 1'b1}; frm_wr = 1'b0; end
      ST_WR:   begin frm_cmd = {1'b1, ram_q, addr_q, 1'b0}; frm_wdata = wd_q; end
      ST_LOCK: frm_wdata = WP_SET;
      ST_PWR:  begin frm_cmd = {2'b11, 5'd0, 1'b0}; frm_wdata = PROBE_PAT; end
      ST_PRD:  begin frm_cmd = {2'b11, 5'd0, 1'b1}; frm_wr = 1'b0; end
      default: ;
    endcase
  end

  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    addr_d = addr_q;
    ram_d  = ram_q;
    wd_d   = wd_q;
    rsp_d  = rsp_q;
    ok_d   = ok_q;
    ro_d   = ro_q;
    wait_d = wait_q;
    if (frm_start) wait_d = 1'b1;
    case (st_q)
      ST_IDLE: if (cmd_valid) begin
        op_d   = op_e'(cmd_op);
        addr_d = cmd_addr;
        wd_d   = cmd_wdata;
        ro_d   = read_only;
        rsp_d  = '0;
        ok_d   = 1'b1;
        wait_d = 1'b0;
        ram_d  = 1'b0;
        case (op_e'(cmd_op))
          OP_REG_RD: st_d = ST_RD;
          OP_RAM_RD: begin ram_d = 1'b1; st_d = ST_RD; end
          OP_REG_WR: begin
            if (read_only && (cmd_addr != TRICKLE_IDX)) begin ok_d = 1'b0; st_d = ST_DONE; end
            else st_d = ST_UNLK;
          end
          OP_RAM_WR: begin
            ram_d = 1'b1;
            if (read_only) begin ok_d = 1'b0; st_d = ST_DONE; end
            else st_d = ST_UNLK;
          end
          OP_TRICKLE: begin
            addr_d = TRICKLE_IDX;
            wd_d   = {TRICKLE_HI, cmd_wdata[3:0]};
            st_d   = ST_UNLK;
          end
          OP_PROBE: begin ram_d = 1'b1; addr_d = '0; st_d = ST_UNLK; end
          OP_INIT:  begin addr_d = SEC_IDX; st_d = ST_RD; end
          default:  begin ok_d = 1'b0; st_d = ST_DONE; end
        endcase
      end
      ST_DONE: st_d = ST_IDLE;
      default: if (frm_done) begin
        wait_d = 1'b0;
        case (st_q)
          ST_RD: begin
            rsp_d = frm_rdata;
            if (op_q == OP_INIT) begin
              wd_d = {1'b0, frm_rdata[6:0]};
              if (ro_q) begin ok_d = 1'b0; st_d = ST_DONE; end
              else st_d = ST_UNLK;
            end else st_d = ST_DONE;
          end
          ST_UNLK: st_d = (op_q == OP_PROBE) ? ST_PWR : ST_WR;
          ST_WR:   st_d = ST_LOCK;
          ST_PWR:  st_d = ST_PRD;
          ST_PRD: begin
            rsp_d = frm_rdata;
            ok_d  = (frm_rdata == PROBE_PAT);
            st_d  = ST_LOCK;
          end
          default: st_d = ST_DONE;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_NONE;
      addr_q <= '0;
      ram_q  <= 1'b0;
      wd_q   <= '0;
      rsp_q  <= '0;
      ok_q   <= 1'b0;
      ro_q   <= 1'b0;
      wait_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      ram_q  <= ram_d;
      wd_q   <= wd_d;
      rsp_q  <= rsp_d;
      ok_q   <= ok_d;
      ro_q   <= ro_d;
      wait_q <= wait_d;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign done     = (st_q == ST_DONE);
  assign rsp_data = rsp_q;
  assign rsp_ok   = ok_q;
endmodule

// File: rtl/rtc3w_master.sv
module rtc3w_master #(
  parameter int CLK_DIV        = 250,
  parameter int CE_SETUP_TICKS = 5,
  parameter int CE_HOLD_TICKS  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [2:0] cmd_op,
  input  logic [4:0] cmd_addr,
  input  logic [7:0] cmd_wdata,
  input  logic       read_only,
  output logic       busy,
  output logic       done,
  output logic [7:0] rsp_data,
  output logic       rsp_ok,
  output logic       rtc_ce,
  output logic       rtc_sclk,
  output logic       rtc_dq_o,
  output logic       rtc_dq_oe,
  input  logic       rtc_dq_i
);
  logic       tick;
  logic       frm_start, frm_wr, frm_done;
  logic [7:0] frm_cmd, frm_wdata, frm_rdata;
  logic       busy_w;

  assign busy      = busy_w;
  assign cmd_ready = !busy_w;

  rtc3w_tick #(.DIV(CLK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (frm_start),
    .tick  (tick)
  );

  rtc3w_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .read_only (read_only),
    .busy      (busy_w),
    .done      (done),
    .rsp_data  (rsp_data),
    .rsp_ok    (rsp_ok),
    .frm_start (frm_start),
    .frm_cmd   (frm_cmd),
    .frm_wr    (frm_wr),
    .frm_wdata (frm_wdata),
    .frm_done  (frm_done),
    .frm_rdata (frm_rdata)
  );

  rtc3w_frame #(
    .SETUP_TICKS (CE_SETUP_TICKS),
    .HOLD_TICKS  (CE_HOLD_TICKS)
  ) u_frame (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .start (frm_start),
    .cmd   (frm_cmd),
    .wr    (frm_wr),
    .wdata (frm_wdata),
    .fdone (frm_done),
    .rdata (frm_rdata),
    .ce    (rtc_ce),
    .sclk  (rtc_sclk),
    .dq_o  (rtc_dq_o),
    .dq_oe (rtc_dq_oe),
    .dq_i  (rtc_dq_i)
  );
endmodule

// File: rtl/rtc3w_master_chk.sv
module rtc3w_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic busy,
  input logic done,
  input logic rtc_ce,
  input logic rtc_sclk,
  input logic rtc_dq_o,
  input logic rtc_dq_oe
);
  // R1
  ce_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !rtc_ce);
  // R1
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n) rtc_sclk |-> rtc_ce);
  // R3
  oe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n) rtc_dq_oe |-> rtc_ce);
  // R2
  dq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rtc_sclk && $past(rtc_sclk)) |-> $stable(rtc_dq_o));
  // R11
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);
  // R11
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_ready == !busy);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R11
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);
endmodule

bind rtc3w_master rtc3w_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .busy      (busy),
  .done      (done),
  .rtc_ce    (rtc_ce),
  .rtc_sclk  (rtc_sclk),
  .rtc_dq_o  (rtc_dq_o),
  .rtc_dq_oe (rtc_dq_oe)
);

// File: tb/rtc3w_master_tb.sv
`timescale 1ns/1ps
module rtc3w_master_tb;
  localparam int DIV   = 4;
  localparam int SETUP = 5;
  localparam int HOLD  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [4:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic       read_only = 1'b0;
  logic       busy, done, rsp_ok;
  logic [7:0] rsp_data;
  logic       rtc_ce, rtc_sclk, rtc_dq_o, rtc_dq_oe;
  logic       m_dq = 1'b0;

  always #2 clk = ~clk;

  rtc3w_master #(.CLK_DIV(DIV), .CE_SETUP_TICKS(SETUP), .CE_HOLD_TICKS(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .read_only(read_only),
    .busy(busy), .done(done), .rsp_data(rsp_data), .rsp_ok(rsp_ok),
    .rtc_ce(rtc_ce), .rtc_sclk(rtc_sclk), .rtc_dq_o(rtc_dq_o), .rtc_dq_oe(rtc_dq_oe),
    .rtc_dq_i(m_dq)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [7:0] m_reg [32];
  logic [7:0] m_ram [32];
  logic       m_fault = 1'b0;
  int         m_bit = 0;
  logic [7:0] m_cmd = '0;
  logic [7:0] m_dat = '0;
  logic [7:0] log_cmd [16];
  logic [7:0] log_dat [16];
  int         log_n = 0;
  int         drv_err = 0;

  always @(posedge rtc_ce) m_bit = 0;

  always @(posedge rtc_sclk) if (rtc_ce) begin
    if (m_bit < 8) begin
      if (rtc_dq_oe !== 1'b1) drv_err++;
      m_cmd[m_bit] = rtc_dq_o;
      if (m_bit == 7 && m_cmd[0]) begin
        m_dat = m_cmd[6] ? m_ram[m_cmd[5:1]] : m_reg[m_cmd[5:1]];
        if (m_fault) m_dat = ~m_dat;
        m_dq = m_dat[0];
      end
    end else if (m_cmd[0]) begin
      if (rtc_dq_oe !== 1'b0) drv_err++;
      if (m_bit < 15) m_dq = m_dat[m_bit - 7];
      else if (log_n < 16) begin
        log_cmd[log_n] = m_cmd; log_dat[log_n] = m_dat; log_n++;
      end
    end else begin
      if (rtc_dq_oe !== 1'b1) drv_err++;
      m_dat[m_bit - 8] = rtc_dq_o;
      if (m_bit == 15) begin
        if (!m_cmd[6] && m_cmd[5:1] == 5'd7) m_reg[7] = m_dat;
        else if (!m_reg[7][7]) begin
          if (m_cmd[6]) m_ram[m_cmd[5:1]] = m_dat;
          else          m_reg[m_cmd[5:1]] = m_dat;
        end
        if (log_n < 16) begin
          log_cmd[log_n] = m_cmd; log_dat[log_n] = m_dat; log_n++;
        end
      end
    end
    m_bit++;
  end

  // ---------------- pin timing monitor ----------------
  int   cyc = 0;
  int   ce_low_cnt = 0;
  int   hi_cnt = 0;
  int   gap_err = 0;
  int   width_err = 0;
  int   dq_err = 0;
  int   done_cnt = 0;
  logic prev_ce = 1'b0, prev_sclk = 1'b0, prev_dq = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (done) done_cnt++;
      if (rtc_ce) begin
        if (!prev_ce) begin
          if (ce_low_cnt < SETUP * DIV) gap_err++;
          if (prev_sclk) gap_err++;
        end
        ce_low_cnt = 0;
      end else begin
        ce_low_cnt++;
        if (rtc_sclk) gap_err++;
      end
      if (rtc_sclk) begin
        hi_cnt++;
        if (prev_sclk && rtc_dq_o != prev_dq) dq_err++;
      end else if (prev_sclk) begin
        if (hi_cnt != DIV) width_err++;
        hi_cnt = 0;
      end
    end
    prev_ce = rtc_ce; prev_sclk = rtc_sclk; prev_dq = rtc_dq_o;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- host helpers ----------------
  logic [7:0] r_data;
  logic       r_ok;

  task automatic run_op(input logic [2:0] op, input logic [4:0] a, input logic [7:0] wd, input logic ro);
    @(negedge clk);
    while (busy) @(negedge clk);
    log_n = 0; done_cnt = 0;
    cmd_op = op; cmd_addr = a; cmd_wdata = wd; read_only = ro; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    r_data = rsp_data; r_ok = rsp_ok;
    @(negedge clk);
  endtask

  task automatic exp_log(input int i, input logic [7:0] c, input logic [7:0] d, input string req);
    chk(log_cmd[i] == c, req, log_cmd[i], c);
    chk(log_dat[i] == d, req, log_dat[i], d);
  endtask

  task automatic t_reset;
    chk(rtc_ce == 0 && rtc_sclk == 0, "R1 idle pins", {rtc_ce, rtc_sclk}, 0);
    chk(rtc_dq_oe == 0, "R3 idle oe", rtc_dq_oe, 0);
    chk(busy == 0 && cmd_ready == 1, "R11 reset ready", {busy, cmd_ready}, 1);
  endtask

  task automatic t_reg_write;
    run_op(3'd1, 5'd2, 8'h37, 1'b0);
    chk(log_n == 3, "R6 frame count", log_n, 3);
    exp_log(0, 8'h8E, 8'h00, "R6 unlock");
    exp_log(1, 8'h84, 8'h37, "R5 R2 reg write");
    exp_log(2, 8'h8E, 8'h80, "R6 lock");
    chk(m_reg[2] == 8'h37, "R2 device reg", m_reg[2], 8'h37);
    chk(r_ok == 1, "R6 ok", r_ok, 1);
  endtask

  task automatic t_reg_read;
    m_reg[3] = 8'hC6;
    run_op(3'd0, 5'd3, 8'h00, 1'b0);
    chk(log_n == 1 && log_cmd[0] == 8'h87, "R5 read cmd", log_cmd[0], 8'h87);
    chk(r_data == 8'hC6, "R4 read data", r_data, 8'hC6);
    chk(rtc_ce == 0, "R1 ce low after", rtc_ce, 0);
  endtask

  task automatic t_ram;
    run_op(3'd3, 5'd5, 8'hA5, 1'b0);
    exp_log(1, 8'hCA, 8'hA5, "R5 R6 ram write");
    chk(m_ram[5] == 8'hA5, "R6 ram stored", m_ram[5], 8'hA5);
    run_op(3'd2, 5'd5, 8'h00, 1'b0);
    chk(log_cmd[0] == 8'hCB, "R5 ram read cmd", log_cmd[0], 8'hCB);
    chk(r_data == 8'hA5, "R4 ram read data", r_data, 8'hA5);
  endtask

  task automatic t_read_only;
    m_reg[4] = 8'h11;
    run_op(3'd1, 5'd4, 8'h99, 1'b1);
    chk(log_n == 0, "R7 no frames", log_n, 0);
    chk(r_ok == 0, "R7 ok low", r_ok, 0);
    chk(done_cnt == 1, "R7 done once", done_cnt, 1);
    run_op(3'd0, 5'd4, 8'h00, 1'b0);
    chk(r_data == 8'h11, "R7 reg unchanged", r_data, 8'h11);
    run_op(3'd3, 5'd6, 8'h77, 1'b1);
    chk(log_n == 0 && r_ok == 0, "R7 ram write blocked", log_n, 0);
    run_op(3'd1, 5'd8, 8'hA3, 1'b1);
    chk(log_n == 3 && m_reg[8] == 8'hA3, "R7 charger reg allowed", m_reg[8], 8'hA3);
  endtask

  task automatic t_trickle;
    run_op(3'd6, 5'd0, 8'h5B, 1'b1);
    chk(log_n == 3, "R8 frame count", log_n, 3);
    exp_log(0, 8'h8E, 8'h00, "R8 unlock");
    exp_log(1, 8'h90, 8'hAB, "R8 charger write");
    exp_log(2, 8'h8E, 8'h80, "R8 lock");
    chk(r_ok == 1, "R8 ok", r_ok, 1);
  endtask

  task automatic t_probe;
    run_op(3'd4, 5'd9, 8'h00, 1'b0);
    chk(log_n == 4, "R9 frame count", log_n, 4);
    exp_log(1, 8'hC0, 8'h42, "R9 pattern write");
    exp_log(2, 8'hC1, 8'h42, "R9 readback");
    exp_log(3, 8'h8E, 8'h80, "R9 lock");
    chk(r_ok == 1 && r_data == 8'h42, "R9 match", {r_ok, r_data}, 9'h142);
    m_fault = 1'b1;
    run_op(3'd4, 5'd0, 8'h00, 1'b0);
    m_fault = 1'b0;
    chk(r_ok == 0, "R9 mismatch", r_ok, 0);
    chk(r_data == 8'hBD, "R9 mismatch data", r_data, 8'hBD);
  endtask

  task automatic t_init;
    m_reg[0] = 8'hA5;
    run_op(3'd5, 5'd3, 8'h00, 1'b1);
    chk(log_n == 1 && log_cmd[0] == 8'h81, "R10 read-only init", log_n, 1);
    chk(m_reg[0] == 8'hA5 && r_ok == 0, "R10 halt kept", m_reg[0], 8'hA5);
    run_op(3'd5, 5'd3, 8'h00, 1'b0);
    chk(log_n == 4, "R10 frame count", log_n, 4);
    exp_log(0, 8'h81, 8'hA5, "R10 seconds read");
    exp_log(2, 8'h80, 8'h25, "R10 halt cleared");
    chk(r_data == 8'hA5, "R10 rsp data", r_data, 8'hA5);
    chk(m_reg[0] == 8'h25, "R10 device seconds", m_reg[0], 8'h25);
  endtask

  task automatic t_busy_ignore;
    m_reg[1] = 8'h3C;
    @(negedge clk);
    log_n = 0; done_cnt = 0;
    cmd_op = 3'd0; cmd_addr = 5'd1; read_only = 1'b0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk(cmd_ready == 0, "R11 ready low when busy", cmd_ready, 0);
    cmd_op = 3'd1; cmd_addr = 5'd1; cmd_wdata = 8'hEE; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (300) @(negedge clk);
    chk(log_n == 1, "R11 extra command ignored", log_n, 1);
    chk(done_cnt == 1, "R11 single done", done_cnt, 1);
    chk(m_reg[1] == 8'h3C, "R11 no write", m_reg[1], 8'h3C);
  endtask

  task automatic t_undefined;
    run_op(3'd7, 5'd0, 8'h00, 1'b0);
    chk(log_n == 0 && r_ok == 0, "R13 code 7 no-op", log_n, 0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin m_reg[i] = 8'h00; m_ram[i] = 8'h00; end
    m_reg[7] = 8'h80;
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_reg_write;
    t_reg_read;
    t_ram;
    t_read_only;
    t_trickle;
    t_probe;
    t_init;
    t_busy_ignore;
    t_undefined;
    chk(m_reg[7] == 8'h80, "R6 left protected", m_reg[7], 8'h80);
    chk(drv_err == 0, "R3 output enable", drv_err, 0);
    chk(gap_err == 0, "R1 strobe setup", gap_err, 0);
    chk(dq_err == 0, "R2 data stable high", dq_err, 0);
    chk(width_err == 0, "R12 high width", width_err, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule